// File: doc/BRIEF.md
# Multiplexed External Data Bus Sequencer

This block runs single external data memory transfers over a shared address/data bus of the kind used by small 8-bit controllers. A requester raises `req_valid` for one clock while the block is idle. With it the requester gives the direction, the addressing kind (16-bit pointer or 8-bit register-indirect), the low and high address bytes, the write byte, a strobe-stretch bit and a page-mode bit. The block then plays out a fixed sequence. First comes an address strobe on `ale` with the low address on the low port. After that it drives or releases the low port for the data phase, asserts the active-low read or write strobe for a short or a long count, and raises `done` for one clock. Read data stays on `rdata` from the `done` clock until the next read completes.

The high port normally mirrors the `p2_reg` input, which holds the port's latched register value. During a 16-bit pointer access with page mode off, it shows the pointer's high byte instead. During a register-indirect access, or a pointer access with page mode on, it keeps mirroring `p2_reg`.

The controller has seven states. IDLE goes to ADDR when a request arrives. ADDR goes to AHOLD. AHOLD goes to WSETUP on a write and to STROBE on a read. WSETUP goes to STROBE. STROBE loops until its last clock, then goes to WHOLD on a write and to FINISH on a read. WHOLD goes to FINISH, and FINISH goes back to IDLE. The strobe is asserted only in STROBE, and `done` is raised only in FINISH.

Top module: `xbus_seq`

## Requirements
- R1: After reset and whenever idle: `ale`=0, `rd_n`=1, `wr_n`=1, `p0_oe`=0, `p0_out`=0, `done`=0, `p2_out` follows `p2_reg`; `rdata` is 0 after reset.
- R2: In the clock after a request is accepted, `ale` is 1 for exactly one clock with `p0_oe`=1 and `p0_out`=`req_addr_lo`. In the next clock `ale` is 0 and the same byte is still driven.
- R3: With `req_stretch`=0 the strobe (`rd_n` or `wr_n`) is low for exactly 3 consecutive clocks.
- R4: With `req_stretch`=1 the strobe is low for exactly 15 consecutive clocks.
- R5: On a write (`req_write`=1), `p0_out`=`req_wdata` with `p0_oe`=1 in the clock before `wr_n` falls, for every clock with `wr_n` low, and in the clock after `wr_n` rises.
- R6: On a read, `p0_oe`=0 and `p0_out`=0 while `rd_n` is low. The value on `p0_in` during the last low clock of `rd_n` appears on `rdata` from the next clock and stays there until the next read samples again.
- R7: From the `ale` clock to the clock before `done`, `p2_out`=`req_addr_hi` when `req_short`=0 and `req_page`=0. It equals the live `p2_reg` when `req_short`=1 or `req_page`=1.
- R8: `done` is 1 for one clock directly after the last bus clock (the last strobe clock on a read, the hold clock on a write), with `p2_out`=`p2_reg` and both strobes high. A read takes 3+N clocks from `ale` to `done` inclusive, and a write takes 5+N, where N is the strobe length.
- R9: Requests are taken only in the idle state. A `req_valid` held high from the `ale` clock through the `done` clock changes no output. If it is still high in the following idle clock, it starts a new transfer.
- R10: `rd_n` and `wr_n` are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = 8-bit register-indirect, 0 = 16-bit pointer |
| req_addr_lo | input | 8 | Low address byte |
| req_addr_hi | input | 8 | Pointer high byte |
| req_wdata | input | 8 | Write byte |
| req_stretch | input | 1 | 1 = 15-clock strobe, 0 = 3-clock strobe |
| req_page | input | 1 | 1 = high port keeps register value on pointer access |
| p2_reg | input | 8 | High port register value |
| p0_in | input | 8 | Low port input from the bus |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| p0_out | output | 8 | Low port output value |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High port output |
| rdata | output | 8 | Last read byte |
| done | output | 1 | One-clock transfer completion |

## Verification
The bench targets the strobe count boundary, under both stretch settings, on both read and write. A counter that is off by one would show up as a strobe of 2 or 4 clocks, or a `done` that comes one clock early or late. `p0_in` changes on every clock, so a design that samples one clock early or late, or after `rd_n` rises, gets the wrong `rdata`. `p2_reg` keeps changing and all three high-port selections are used, which exposes a high port that latches the register value or shows the pointer byte in page mode. `req_valid` is also held high with changing fields through the busy clocks and the `done` clock. A design that re-arms early would restart the bus mid-transfer.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AHOLD,
        ST_WSETUP,
        ST_STROBE,
        ST_WHOLD,
        ST_FINISH
    } xbus_state_t;
endpackage

// File: rtl/xbus_ctrl_fsm.sv
module xbus_ctrl_fsm
    import xbus_pkg::*;
#(
    parameter int SHORT_LEN = 3,
    parameter int LONG_LEN  = 15,
    parameter int CNT_W     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_stretch,
    output xbus_state_t state,
    output logic        load,
    output logic        last_strobe,
    output logic        ale,
    output logic        rd_n,
    output logic        wr_n,
    output logic        done
);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

    xbus_state_t      state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             write_q;
    logic             stretch_q;

    assign load        = (state == ST_IDLE) && req_valid;
    assign last_strobe = (cnt_q == (stretch_q ? LONG_LAST : SHORT_LAST));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt_q     <= '0;
            write_q   <= 1'b0;
            stretch_q <= 1'b0;
        end else begin
            state <= state_nx;
            cnt_q <= (state == ST_STROBE) ? cnt_q + 1'b1 : '0;
            if (load) begin
                write_q   <= req_write;
                stretch_q <= req_stretch;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_ADDR;
            ST_ADDR:   state_nx = ST_AHOLD;
            ST_AHOLD:  state_nx = write_q ? ST_WSETUP : ST_STROBE;
            ST_WSETUP: state_nx = ST_STROBE;
            ST_STROBE: if (last_strobe) state_nx = write_q ? ST_WHOLD : ST_FINISH;
            ST_WHOLD:  state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ale  = 1'b0;
        rd_n = 1'b1;
        wr_n = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_ADDR:   ale = 1'b1;
            ST_STROBE: begin
                rd_n = write_q;
                wr_n = !write_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // strobe-length checker: run length of the low strobe
    logic [CNT_W:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) low_run_q <= '0;
        else if (!rd_n || !wr_n) low_run_q <= low_run_q + 1'b1;
        else low_run_q <= '0;
    end

    // R3 R4
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n && low_run_q != '0) |->
        (low_run_q == (stretch_q ? (CNT_W+1)'(LONG_LEN) : (CNT_W+1)'(SHORT_LEN))));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
    import xbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xbus_state_t   state,
    input  logic          load,
    input  logic          last_strobe,
    input  logic          req_write,
    input  logic          req_short,
    input  logic          req_page,
    input  logic [DW-1:0] req_addr_lo,
    input  logic [DW-1:0] req_addr_hi,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] p2_reg,
    input  logic [DW-1:0] p0_in,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] lo_q, hi_q, wd_q;
    logic          use_reg_q;
    logic          write_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            hi_q      <= '0;
            wd_q      <= '0;
            use_reg_q <= 1'b1;
            write_q   <= 1'b0;
            rdata     <= '0;
        end else begin
            if (load) begin
                lo_q      <= req_addr_lo;
                hi_q      <= req_addr_hi;
                wd_q      <= req_wdata;
                use_reg_q <= req_short || req_page;
                write_q   <= req_write;
            end
            if (state == ST_STROBE && last_strobe && !write_q)
                rdata <= p0_in;
        end
    end

    always_comb begin
        p0_oe  = 1'b0;
        p0_out = '0;
        p2_out = use_reg_q ? p2_reg : hi_q;
        unique case (state)
            ST_IDLE, ST_FINISH: p2_out = p2_reg;
            ST_ADDR, ST_AHOLD: begin
                p0_oe  = 1'b1;
                p0_out = lo_q;
            end
            ST_WSETUP, ST_WHOLD: begin
                p0_oe  = 1'b1;
                p0_out = wd_q;
            end
            ST_STROBE: begin
                p0_oe  = write_q;
                p0_out = write_q ? wd_q : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
    parameter int DW        = 8,
    parameter int SHORT_LEN = 3,
    parameter int LONG_LEN  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_short,
    input  logic [DW-1:0] req_addr_lo,
    input  logic [DW-1:0] req_addr_hi,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_stretch,
    input  logic          req_page,
    input  logic [DW-1:0] p2_reg,
    input  logic [DW-1:0] p0_in,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic [DW-1:0] rdata,
    output logic          done
);
    localparam int CNT_W = $clog2(LONG_LEN + 1);

    xbus_pkg::xbus_state_t state;
    logic load, last_strobe;

    xbus_ctrl_fsm #(
        .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .CNT_W(CNT_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_stretch(req_stretch),
        .state(state), .load(load), .last_strobe(last_strobe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .done(done)
    );

    xbus_port_mux #(.DW(DW)) port_i (
        .clk(clk), .rst_n(rst_n), .state(state), .load(load),
        .last_strobe(last_strobe), .req_write(req_write),
        .req_short(req_short), .req_page(req_page),
        .req_addr_lo(req_addr_lo), .req_addr_hi(req_addr_hi),
        .req_wdata(req_wdata), .p2_reg(p2_reg), .p0_in(p0_in),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .rdata(rdata)
    );

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2
    ale_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && p0_oe && p0_out == $past(p0_out)));

    // R6
    read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !p0_oe);

    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && !$past(wr_n)) |-> (p0_oe && p0_out == $past(p0_out)));

    // R8
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && !ale && p2_out == p2_reg));
endmodule

// File: tb/xbus_seq_tb_top.sv
`timescale 1ns/1ps
module xbus_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, req_short = 1'b0;
    logic [7:0] req_addr_lo = '0, req_addr_hi = '0, req_wdata = '0;
    logic       req_stretch = 1'b0, req_page = 1'b0;
    logic [7:0] p2_reg = 8'h5A, p0_in = '0;
    logic       ale, rd_n, wr_n, p0_oe, done;
    logic [7:0] p0_out, p2_out, rdata;

    int  n_chk = 0, n_bad = 0;
    bit  chk_on = 1'b0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    xbus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_short(req_short), .req_addr_lo(req_addr_lo), .req_addr_hi(req_addr_hi),
        .req_wdata(req_wdata), .req_stretch(req_stretch), .req_page(req_page),
        .p2_reg(p2_reg), .p0_in(p0_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out), .rdata(rdata), .done(done)
    );

    typedef struct packed {
        logic       ale;
        logic       rdn;
        logic       wrn;
        logic       oe;
        logic [7:0] p0;
        logic       p2sel;
        logic [7:0] p2;
        logic       done;
        logic       smp;
    } exp_t;

    exp_t       q[$];
    logic [7:0] exp_rdata = '0;

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push_e(input logic a, input logic r, input logic w, input logic o,
                          input logic [7:0] p0, input logic ps, input logic [7:0] p2,
                          input logic d, input logic s);
        exp_t e;
        e.ale = a; e.rdn = r; e.wrn = w; e.oe = o; e.p0 = p0;
        e.p2sel = ps; e.p2 = p2; e.done = d; e.smp = s;
        q.push_back(e);
    endtask

    task automatic build_seq();
        int   n;
        logic ps;
        n  = req_stretch ? 15 : 3;
        ps = req_short | req_page;
        push_e(1, 1, 1, 1, req_addr_lo, ps, req_addr_hi, 0, 0);
        push_e(0, 1, 1, 1, req_addr_lo, ps, req_addr_hi, 0, 0);
        if (req_write) begin
            push_e(0, 1, 1, 1, req_wdata, ps, req_addr_hi, 0, 0);
            for (int i = 0; i < n; i++)
                push_e(0, 1, 0, 1, req_wdata, ps, req_addr_hi, 0, 0);
            push_e(0, 1, 1, 1, req_wdata, ps, req_addr_hi, 0, 0);
        end else begin
            for (int i = 0; i < n; i++)
                push_e(0, 0, 1, 0, 8'h00, ps, req_addr_hi, 0, (i == n - 1));
        end
        push_e(0, 1, 1, 0, 8'h00, 1, 8'h00, 1, 0);
    endtask

    // reference model, compared every clock at the falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            exp_t e;
            bit   idle;
            idle = (q.size() == 0);
            if (idle) begin
                e.ale = 0; e.rdn = 1; e.wrn = 1; e.oe = 0; e.p0 = 0;
                e.p2sel = 1; e.p2 = 0; e.done = 0; e.smp = 0;
            end else begin
                e = q.pop_front();
            end
            chk(idle ? "R1 R9" : "R2", "ale", {7'd0, ale}, {7'd0, e.ale});
            chk(idle ? "R1 R9" : "R3 R4 R6", "rd_n", {7'd0, rd_n}, {7'd0, e.rdn});
            chk(idle ? "R1 R9" : "R3 R4 R5", "wr_n", {7'd0, wr_n}, {7'd0, e.wrn});
            chk(idle ? "R1 R9" : "R2 R5 R6", "p0_oe", {7'd0, p0_oe}, {7'd0, e.oe});
            chk(idle ? "R1 R9" : "R2 R5 R6", "p0_out", p0_out, e.p0);
            chk(idle ? "R1 R9" : "R7", "p2_out", p2_out, e.p2sel ? p2_reg : e.p2);
            chk(idle ? "R1 R9" : "R8", "done", {7'd0, done}, {7'd0, e.done});
            chk("R6", "rdata", rdata, exp_rdata);
            chk("R10", "rd_n&wr_n low", {7'd0, (!rd_n && !wr_n)}, 8'h00);
            if (e.smp) exp_rdata = p0_in;
            if (idle && req_valid) build_seq();
        end
    end

    // bus-side stimulus: low port input and register value keep moving
    initial forever begin
        @(posedge clk); #1;
        p0_in = 8'($urandom);
    end
    initial forever begin
        repeat (7) @(posedge clk);
        #1 p2_reg = 8'($urandom);
    end

    task automatic set_fields(input logic w, input logic sh, input logic pg,
                              input logic st, input logic [7:0] lo,
                              input logic [7:0] hi, input logic [7:0] wd);
        req_write = w; req_short = sh; req_page = pg; req_stretch = st;
        req_addr_lo = lo; req_addr_hi = hi; req_wdata = wd;
    endtask

    task automatic do_req(input logic w, input logic sh, input logic pg,
                          input logic st, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] wd,
                          input bit noise);
        int n, len;
        n   = st ? 15 : 3;
        len = w ? (5 + n) : (3 + n);
        @(posedge clk); #1;
        set_fields(w, sh, pg, st, lo, hi, wd);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = noise;
        for (int i = 0; i < len; i++) begin
            if (noise) begin
                set_fields(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                           8'($urandom), 8'($urandom), 8'($urandom));
            end
            if (i < len - 1) begin
                @(posedge clk); #1;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic do_b2b(input logic w, input logic st, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] wd);
        int len;
        len = w ? (5 + (st ? 15 : 3)) : (3 + (st ? 15 : 3));
        @(posedge clk); #1;
        set_fields(w, 1'b0, 1'b0, st, lo, hi, wd);
        req_valid = 1'b1;
        repeat (len + 2) @(posedge clk);
        #1 req_valid = 1'b0;
        repeat (len + 3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset ale", {7'd0, ale}, 8'h00);
        chk("R1", "reset rd_n", {7'd0, rd_n}, 8'h01);
        chk("R1", "reset wr_n", {7'd0, wr_n}, 8'h01);
        chk("R1", "reset p0_oe", {7'd0, p0_oe}, 8'h00);
        chk("R1", "reset done", {7'd0, done}, 8'h00);
        chk("R1", "reset rdata", rdata, 8'h00);
        chk("R1", "reset p2_out", p2_out, p2_reg);
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk_on = 1'b1;
        repeat (2) @(posedge clk);
        // R3 R6 R7: pointer read, short strobe, high byte shown
        do_req(0, 0, 0, 0, 8'h12, 8'h34, 8'h00, 0);
        // R3 R5: pointer write, short strobe
        do_req(1, 0, 0, 0, 8'hA1, 8'hB2, 8'hC3, 0);
        // R4 R6: pointer read, long strobe
        do_req(0, 0, 0, 1, 8'h0F, 8'hF0, 8'h00, 0);
        // R4 R5 R7: write, long strobe, page mode keeps register value
        do_req(1, 0, 1, 1, 8'h55, 8'hEE, 8'h99, 0);
        // R7: register-indirect read
        do_req(0, 1, 0, 0, 8'h77, 8'h88, 8'h00, 0);
        // R7 R4: register-indirect write, long strobe
        do_req(1, 1, 0, 1, 8'h3C, 8'hC3, 8'h6D, 0);
        // R9: busy-time requests ignored
        do_req(0, 0, 0, 1, 8'h21, 8'h43, 8'h00, 1);
        do_req(1, 0, 0, 0, 8'h65, 8'h87, 8'hA9, 1);
        do_req(0, 0, 1, 0, 8'hFE, 8'hDC, 8'h00, 1);
        // R9: held request restarts in the idle clock
        do_b2b(0, 0, 8'h11, 8'h22, 8'h00);
        do_b2b(1, 1, 8'h33, 8'h44, 8'h5E);
        repeat (4) @(posedge clk);
        chk("R8", "queue drained", 8'(q.size()), 8'h00);
        chk_on = 1'b0;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule